// File: doc/BRIEF.md
# SMRAM Base Region Guard Register

This block is a one-byte configuration register that decides whether a small window of system RAM, starting at a fixed base address, is hidden from ordinary memory traffic. Firmware first probes the register by writing all-ones. The register answers by reading back a "feature available" code. A second, specific write then closes the window for good. Once closed, the window stays closed until the next system reset. Any other write in the handshake is dropped, so stray configuration traffic cannot open or close the window by chance.

Beside the register sits an address decoder for the guarded window. While the window is closed, every valid memory access that falls inside it raises a block signal. The downstream memory path then discards writes and returns the all-ones fill byte for reads. Accesses outside the window, and all accesses while the window is open, pass through untouched. A static legacy strap turns the block into a plain read/write byte that never blocks anything. This suits platforms that predate the handshake. The strap may change only while reset is asserted.

Top module: `smbase_guard`

## Requirements
- R1: While reset is asserted and directly after it is released, `cfg_rd_data` reads 0x00 and `mem_block` is low for every address.
- R2: With the strap low and the register reading 0x00, a write of any value other than 0xFF, 0x02 included, leaves the register reading 0x00.
- R3: With the strap low and the register reading 0x00, a write of 0xFF makes `cfg_rd_data` read 0x01 from the cycle after the write edge.
- R4: With the strap low and the register reading 0x01, a write of 0x02 makes it read 0x02, and any other write leaves it at 0x01. With the strap low, the register only ever reads 0x00, 0x01 or 0x02.
- R5: With the strap low and the register reading 0x02, writes of every value 0x00 to 0xFF leave it at 0x02 until reset.
- R6: With the register reading 0x02 and the strap low, a valid access to an address A with BASE <= A < BASE+SIZE drives `mem_block` high and `mem_fill_data` to 0xFF in the same cycle. Accesses outside that range, or with `mem_valid` low, give `mem_block` low and `mem_fill_data` 0x00.
- R7: While the register reads 0x00 or 0x01, `mem_block` stays low for every address.
- R8: A reset after the lock returns the register to 0x00, and accesses to the window pass through again.
- R9: With the strap high, every write is stored and read back unchanged from the next cycle, and `mem_block` is never raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low system reset |
| legacy_strap | input | 1 | High selects the plain-byte mode; change only during reset |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_wr_data | input | 8 | Configuration write data |
| cfg_rd_data | output | 8 | Current register value |
| mem_valid | input | 1 | A memory access is presented this cycle |
| mem_addr | input | ADDR_W | Byte address of the memory access |
| mem_block | output | 1 | Access hits the closed window and must not reach RAM |
| mem_fill_data | output | 8 | 0xFF read value while blocked, else 0x00 |

## Verification
The assertions check the following on every cycle: each handshake step, the legal read codes, the stickiness of the lock, the legacy echo, and the fact that a block needs the locked code and a valid access. The bench shows what needs a chosen scenario. This covers the exact window edges at BASE-1, BASE, BASE+SIZE-1 and BASE+SIZE, and the full sweep of write values before negotiation and after the lock. It also covers the reset state, the recovery after a reset from the locked state, and the legacy strap held through writes of 0xFF and 0x02.

// File: rtl/smbase_pkg.sv
package smbase_pkg;

    typedef enum logic [1:0] {
        NEG_IDLE   = 2'd0,
        NEG_AVAIL  = 2'd1,
        NEG_LOCKED = 2'd2
    } neg_state_e;

    typedef struct packed {
        neg_state_e st;
        logic [7:0] plain;
    } neg_regs_t;

    localparam logic [7:0] CODE_PROBE  = 8'hFF;
    localparam logic [7:0] CODE_LOCK   = 8'h02;
    localparam logic [7:0] RD_IDLE     = 8'h00;
    localparam logic [7:0] RD_AVAIL    = 8'h01;
    localparam logic [7:0] RD_LOCKED   = 8'h02;
    localparam logic [7:0] FILL_BYTE   = 8'hFF;

endpackage

// File: rtl/smbase_neg_ctrl.sv
module smbase_neg_ctrl
    import smbase_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             legacy,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output neg_state_e       state,
    output logic [7:0]       plain
);

    neg_regs_t regs_d, regs_q;

    // Next-state: handshake in normal mode, plain storage in legacy mode.
    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (legacy) begin
                regs_d.plain = wr_data;
            end else begin
                unique case (regs_q.st)
                    NEG_IDLE:  if (wr_data == CODE_PROBE) regs_d.st = NEG_AVAIL;
                    NEG_AVAIL: if (wr_data == CODE_LOCK)  regs_d.st = NEG_LOCKED;
                    default:   regs_d.st = regs_q.st;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.st    <= NEG_IDLE;
            regs_q.plain <= 8'h00;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign state = regs_q.st;
    assign plain = regs_q.plain;

endmodule

// File: rtl/smbase_range_dec.sv
module smbase_range_dec #(
    parameter int unsigned ADDR_W      = 32,
    parameter logic [63:0] REGION_BASE = 64'h0000_0000_0003_0000,
    parameter logic [63:0] REGION_SIZE = 64'h0000_0000_0002_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    localparam logic [63:0]     END_FULL = REGION_BASE + REGION_SIZE;
    localparam logic [ADDR_W:0] LO_BOUND = REGION_BASE[ADDR_W:0];
    localparam logic [ADDR_W:0] HI_BOUND = END_FULL[ADDR_W:0];

    logic [ADDR_W:0] addr_x;
    logic            above_lo;
    logic            below_hi;

    assign addr_x = {1'b0, addr};

    // A window starting at zero needs no lower compare.
    generate
        if (REGION_BASE == 64'd0) begin : g_zero_base
            assign above_lo = 1'b1;
        end else begin : g_cmp_base
            assign above_lo = (addr_x >= LO_BOUND);
        end
    endgenerate

    assign below_hi = (addr_x < HI_BOUND);
    assign hit      = above_lo && below_hi;

endmodule

// File: rtl/smbase_rd_mux.sv
module smbase_rd_mux
    import smbase_pkg::*;
(
    input  logic       legacy,
    input  neg_state_e state,
    input  logic [7:0] plain,
    output logic [7:0] rd_data,
    output logic       locked
);

    always_comb begin
        if (legacy) begin
            rd_data = plain;
        end else begin
            unique case (state)
                NEG_IDLE:   rd_data = RD_IDLE;
                NEG_AVAIL:  rd_data = RD_AVAIL;
                NEG_LOCKED: rd_data = RD_LOCKED;
                default:    rd_data = RD_IDLE;
            endcase
        end
    end

    assign locked = !legacy && (state == NEG_LOCKED);

endmodule

// File: rtl/smbase_guard.sv
module smbase_guard
    import smbase_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter logic [63:0] REGION_BASE = 64'h0000_0000_0003_0000,
    parameter logic [63:0] REGION_SIZE = 64'h0000_0000_0002_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              legacy_strap,
    input  logic              cfg_wr_en,
    input  logic [7:0]        cfg_wr_data,
    output logic [7:0]        cfg_rd_data,
    input  logic              mem_valid,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic              mem_block,
    output logic [7:0]        mem_fill_data
);

    neg_state_e neg_state;
    logic [7:0] plain_byte;
    logic       win_locked;
    logic       win_hit;

    smbase_neg_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .legacy  (legacy_strap),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .state   (neg_state),
        .plain   (plain_byte)
    );

    smbase_rd_mux u_rd (
        .legacy  (legacy_strap),
        .state   (neg_state),
        .plain   (plain_byte),
        .rd_data (cfg_rd_data),
        .locked  (win_locked)
    );

    smbase_range_dec #(
        .ADDR_W      (ADDR_W),
        .REGION_BASE (REGION_BASE),
        .REGION_SIZE (REGION_SIZE)
    ) u_dec (
        .addr (mem_addr),
        .hit  (win_hit)
    );

    assign mem_block     = win_locked && mem_valid && win_hit;
    assign mem_fill_data = mem_block ? FILL_BYTE : 8'h00;

endmodule

// File: rtl/smbase_guard_chk.sv
module smbase_guard_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              legacy_strap,
    input logic              cfg_wr_en,
    input logic [7:0]        cfg_wr_data,
    input logic [7:0]        cfg_rd_data,
    input logic              mem_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_block,
    input logic [7:0]        mem_fill_data
);

    assert_idle_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!legacy_strap && cfg_rd_data == 8'h00 && cfg_wr_en && cfg_wr_data != 8'hFF)
        |=> (cfg_rd_data == 8'h00));

    assert_probe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!legacy_strap && cfg_rd_data == 8'h00 && cfg_wr_en && cfg_wr_data == 8'hFF)
        |=> (cfg_rd_data == 8'h01));

    assert_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!legacy_strap && cfg_rd_data == 8'h01 && cfg_wr_en && cfg_wr_data == 8'h02)
        |=> (cfg_rd_data == 8'h02));

    assert_codes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !legacy_strap |-> (cfg_rd_data == 8'h00 || cfg_rd_data == 8'h01 || cfg_rd_data == 8'h02));

    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!legacy_strap && cfg_rd_data == 8'h02) |=> (cfg_rd_data == 8'h02));

    assert_block_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_block |-> (mem_fill_data == 8'hFF && mem_valid && cfg_rd_data == 8'h02 && !legacy_strap));

    assert_open_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!legacy_strap && cfg_rd_data != 8'h02) |-> !mem_block);

    assert_echo_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (legacy_strap && cfg_wr_en) |=> (cfg_rd_data == $past(cfg_wr_data)));

    assert_never_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_strap |-> !mem_block);

endmodule

bind smbase_guard smbase_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .legacy_strap  (legacy_strap),
    .cfg_wr_en     (cfg_wr_en),
    .cfg_wr_data   (cfg_wr_data),
    .cfg_rd_data   (cfg_rd_data),
    .mem_valid     (mem_valid),
    .mem_addr      (mem_addr),
    .mem_block     (mem_block),
    .mem_fill_data (mem_fill_data)
);

// File: tb/sim_smbase_guard.sv
module sim_smbase_guard;

    localparam int          CLK_PERIOD = 10;
    localparam int unsigned AW         = 32;
    localparam logic [31:0] WBASE      = 32'h0003_0000;
    localparam logic [31:0] WSIZE      = 32'h0002_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          legacy_strap = 1'b0;
    logic          cfg_wr_en = 1'b0;
    logic [7:0]    cfg_wr_data = 8'h00;
    logic [7:0]    cfg_rd_data;
    logic          mem_valid = 1'b0;
    logic [AW-1:0] mem_addr = '0;
    logic          mem_block;
    logic [7:0]    mem_fill_data;

    int n_vec = 0;
    int n_bad = 0;

    // Bench model: 0 idle, 1 available, 2 locked.
    int         m_st = 0;
    logic [7:0] m_plain = 8'h00;
    logic       m_legacy = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smbase_guard #(.ADDR_W(AW)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .legacy_strap  (legacy_strap),
        .cfg_wr_en     (cfg_wr_en),
        .cfg_wr_data   (cfg_wr_data),
        .cfg_rd_data   (cfg_rd_data),
        .mem_valid     (mem_valid),
        .mem_addr      (mem_addr),
        .mem_block     (mem_block),
        .mem_fill_data (mem_fill_data)
    );

    function automatic logic [7:0] exp_rd();
        if (m_legacy) return m_plain;
        return 8'(m_st);
    endfunction

    function automatic logic exp_block(logic [31:0] a, logic v);
        return !m_legacy && (m_st == 2) && v && (a >= WBASE) && (a < WBASE + WSIZE);
    endfunction

    task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_reset(logic leg);
        @(negedge clk);
        rst_n = 1'b0;
        legacy_strap = leg;
        cfg_wr_en = 1'b0;
        mem_valid = 1'b1;
        mem_addr = WBASE;
        repeat (2) @(negedge clk);
        check8("R1 reset read", cfg_rd_data, 8'h00);
        check8("R1 reset block", {7'd0, mem_block}, 8'h00);
        rst_n = 1'b1;
        m_st = 0;
        m_plain = 8'h00;
        m_legacy = leg;
        @(negedge clk);
        check8("R1 after release", cfg_rd_data, 8'h00);
    endtask

    task automatic cfg_wr(logic [7:0] v);
        string tag;
        if (m_legacy)      tag = "R9 echo";
        else if (m_st == 0) tag = (v == 8'hFF) ? "R3 probe" : "R2 ignore";
        else if (m_st == 1) tag = "R4 handshake";
        else                tag = "R5 sticky";
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_wr_data = v;
        @(posedge clk);
        if (m_legacy) m_plain = v;
        else if (m_st == 0 && v == 8'hFF) m_st = 1;
        else if (m_st == 1 && v == 8'h02) m_st = 2;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        check8(tag, cfg_rd_data, exp_rd());
    endtask

    task automatic probe(logic [31:0] a, logic v, string req);
        @(negedge clk);
        mem_addr = a;
        mem_valid = v;
        #1;
        check8(req, {7'd0, mem_block}, {7'd0, exp_block(a, v)});
        check8(req, mem_fill_data, exp_block(a, v) ? 8'hFF : 8'h00);
    endtask

    function automatic logic [31:0] pick_addr();
        case ($urandom_range(0, 5))
            0: return WBASE - 1;
            1: return WBASE;
            2: return WBASE + WSIZE - 1;
            3: return WBASE + WSIZE;
            4: return WBASE + 32'($urandom_range(0, 32'h1FFFF));
            default: return 32'($urandom_range(0, 32'h7FFFF));
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset(1'b0);
        probe(WBASE, 1'b1, "R7 open window");
        for (int i = 0; i < 255; i++) cfg_wr(8'(i));  // R2 sweep incl. 0x02
        probe(WBASE, 1'b1, "R7 still idle");
        cfg_wr(8'hFF);                                // R3
        probe(WBASE + 5, 1'b1, "R7 available");
        cfg_wr(8'h55);                                // R4 ignored
        cfg_wr(8'hFF);                                // R4 ignored
        cfg_wr(8'h02);                                // R4 lock
        probe(WBASE - 1, 1'b1, "R6 below");
        probe(WBASE, 1'b1, "R6 first");
        probe(WBASE + WSIZE - 1, 1'b1, "R6 last");
        probe(WBASE + WSIZE, 1'b1, "R6 above");
        probe(WBASE, 1'b0, "R6 idle bus");
        for (int i = 0; i < 256; i++) begin
            cfg_wr(8'(i));                            // R5
            probe(WBASE + 32'(i), 1'b1, "R6 locked sweep");
        end
        do_reset(1'b0);
        probe(WBASE, 1'b1, "R8 unblocked after reset");
        check8("R8 reg after reset", cfg_rd_data, 8'h00);
        do_reset(1'b1);
        for (int i = 0; i < 256; i++) cfg_wr(8'(255 - i));  // R9
        cfg_wr(8'hFF);
        cfg_wr(8'h02);
        probe(WBASE, 1'b1, "R9 never blocks");
        for (int k = 0; k < 3000; k++) begin
            int op;
            op = $urandom_range(0, 99);
            if (op < 2) begin
                do_reset(1'($urandom_range(0, 3) == 0));
            end else if (op < 50) begin
                int sel;
                sel = $urandom_range(0, 3);
                cfg_wr(sel == 0 ? 8'hFF : sel == 1 ? 8'h02 : 8'($urandom_range(0, 255)));
            end else begin
                probe(pick_addr(), 1'($urandom_range(0, 7) != 0), "R6 random access");
            end
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule